// File: doc/BRIEF.md
# Auxiliary Control Register with Address-Latch Strobe Generator

This block holds a small auxiliary control register on a byte-wide special-function-register bus inside an 8-bit microcontroller whose machine cycle lasts six oscillator clocks. It also drives the address-latch-enable (ALE) pin. One register bit selects how ALE behaves. In the default mode ALE pulses once per machine cycle. In the quiet mode it pulses only in machine cycles where the core reports an external data move or code-table read, which cuts switching noise on the pin. A second register bit drives the enable level of the converter's charge pump. The pump is needed when the part runs from a low supply.

The core writes and reads the register through address, data, write-enable and read-enable strobes. Read data is combinational and reads as zero when the register is not selected. ALE comes from a free-running modulo-6 phase counter. A mode change waits for the next machine-cycle boundary, so every ALE pulse is exactly one clock wide.

Top module: `aux_ale_ctl`

## Requirements
- R1: When `sfr_re` is 1 and `sfr_addr` equals 8EH, `sfr_rdata` is {5'b00000, 1'b1, pump bit, mode bit} in the same cycle. Otherwise `sfr_rdata` is 00H.
- R2: While `rst_n` is low, the register holds 06H (pump bit 1, mode bit 0) and `ale_o` is 0.
- R3: A write (`sfr_we`=1, address 8EH) loads bit 0 into the mode bit and bit 1 into the pump bit at the clock edge. Write-data bits 7..2 have no effect: bits 7..3 keep reading 0 and bit 2 keeps reading 1.
- R4: A write strobe at any other address, or address 8EH without `sfr_we`, leaves the register unchanged.
- R5: `pump_en_o` equals the pump bit at all times.
- R6: With mode bit 0, `ale_o` is high for exactly one clock in every six. The first pulse occupies the clock that follows the third rising edge after `rst_n` rises.
- R7: With mode bit 1, a pulse slot carries an ALE pulse only if `xmem_busy` was 1 in the clock just before the slot. A busy level elsewhere in the machine cycle gives no pulse.
- R8: A pulse slot uses the mode bit as it stood in the clock before the slot. A write in that clock affects only later slots, and no pulse is ever shorter or longer than one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_re | input | 1 | SFR read strobe |
| xmem_busy | input | 1 | Core reports an external data move or code read in progress |
| sfr_rdata | output | 8 | SFR read data, zero when not selected |
| ale_o | output | 1 | Address-latch-enable strobe |
| pump_en_o | output | 1 | Converter charge-pump enable level |

## Verification
Register traffic runs from a vector table. It mixes hits, misses on a neighbouring address and an address that differs only in its top bit, and strobes with write-enable low. It also writes all-ones and mostly-ones patterns, which separate real field loads from reserved-bit leakage. The ALE checks use three patterns: a free run after reset, which pins down pulse phase and period; gated mode with the busy flag placed at the boundary clock and then in mid-cycle, which shows that it is sampled only at the boundary; and mode writes issued in the boundary clock itself, which separate an old-mode slot from the first new-mode slot.

// File: rtl/aux_ale_pkg.sv
package aux_ale_pkg;

  localparam int AO_BIT   = 0;
  localparam int PUMP_BIT = 1;
  localparam int FIX_BIT  = 2;

  typedef struct packed {
    logic pump;
    logic ao;
  } aux_ctl_t;

  localparam aux_ctl_t CTL_RST = '{pump: 1'b1, ao: 1'b0};

endpackage

// File: rtl/aux_rst_sync.sv
module aux_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/aux_sfr_reg.sv
module aux_sfr_reg
  import aux_ale_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output aux_ctl_t          ctl_o
);

  aux_ctl_t ctl_q;
  aux_ctl_t ctl_d;
  logic     hit;
  logic     wr_en;

  assign hit   = (addr_i == REG_ADDR);
  assign wr_en = we_i && hit;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.ao   = wdata_i[AO_BIT];
      ctl_d.pump = wdata_i[PUMP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CTL_RST;
    else if (wr_en) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata_o = '0;
    if (re_i && hit) begin
      rdata_o[AO_BIT]   = ctl_q.ao;
      rdata_o[PUMP_BIT] = ctl_q.pump;
      rdata_o[FIX_BIT]  = 1'b1;
    end
  end

  assign ctl_o = ctl_q;

  // R1: unselected reads return zero
  p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(re_i && hit) |-> (rdata_o == '0));

  // R3: reserved read-back bits are fixed
  p_rd_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && hit) |-> (rdata_o[DATA_W-1:FIX_BIT] == {{(DATA_W-FIX_BIT-1){1'b0}}, 1'b1}));

  // R3: a hit with reserved ones still loads exactly the two fields
  p_rsvd_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|wdata_i[DATA_W-1:FIX_BIT])) |=>
      (ctl_q == {$past(wdata_i[PUMP_BIT]), $past(wdata_i[AO_BIT])}));

  // R4: no write hit, no change
  p_miss_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));

endmodule

// File: rtl/aux_phase_ctr.sv
module aux_phase_ctr #(
  parameter int CYC_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap_o
);

  localparam int                PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [PH_W-1:0]   LAST = PH_W'(CYC_LEN - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  assign wrap_o = (ph_q == LAST);

  always_comb begin
    if (wrap_o) ph_d = '0;
    else        ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= LAST;
    else        ph_q <= ph_d;
  end

  // R6: phase never leaves the machine cycle
  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST);

  // R6: a boundary is followed by phase zero
  p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (ph_q == '0));

endmodule

// File: rtl/aux_ale_gen.sv
module aux_ale_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic gated_i,
  input  logic busy_i,
  output logic ale_o
);

  logic ale_q;
  logic ale_d;

  always_comb begin
    ale_d = wrap_i && (!gated_i || busy_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ale_q <= 1'b0;
    else        ale_q <= ale_d;
  end

  assign ale_o = ale_q;

  // R6: every pulse is one clock wide
  p_ale_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  // R6: free mode always pulses after a boundary
  p_free_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !gated_i) |=> ale_o);

  // R7: gated mode without busy stays low
  p_gated_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && gated_i && !busy_i) |=> !ale_o);

  // R8: pulses only occupy the slot after a boundary
  p_slot_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> $past(wrap_i));

endmodule

// File: rtl/aux_ale_ctl.sv
module aux_ale_ctl
  import aux_ale_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h8E,
  parameter int                CYC_LEN   = 6,
  parameter int                RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  input  logic              sfr_re,
  input  logic              xmem_busy,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              ale_o,
  output logic              pump_en_o
);

  logic     srst_n;
  logic     wrap;
  aux_ctl_t ctl;

  aux_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  aux_sfr_reg #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
  ) u_reg (
    .clk     (clk),
    .rst_n   (srst_n),
    .addr_i  (sfr_addr),
    .wdata_i (sfr_wdata),
    .we_i    (sfr_we),
    .re_i    (sfr_re),
    .rdata_o (sfr_rdata),
    .ctl_o   (ctl)
  );

  aux_phase_ctr #(.CYC_LEN(CYC_LEN)) u_ph (
    .clk    (clk),
    .rst_n  (srst_n),
    .wrap_o (wrap)
  );

  aux_ale_gen u_ale (
    .clk     (clk),
    .rst_n   (srst_n),
    .wrap_i  (wrap),
    .gated_i (ctl.ao),
    .busy_i  (xmem_busy),
    .ale_o   (ale_o)
  );

  assign pump_en_o = ctl.pump;

  // R5: pump level matches the read-back field
  p_pump_rd_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (sfr_re && sfr_addr == REG_ADDR) |-> (sfr_rdata[PUMP_BIT] == pump_en_o));

  // R2: strobe silent while held in reset
  p_rst_quiet_r2: assert property (@(posedge clk)
    !srst_n |-> !ale_o);

endmodule

// File: tb/sim_aux_ale_ctl.sv
`timescale 1ns/1ps
module sim_aux_ale_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       sfr_we;
  logic       sfr_re;
  logic       xmem_busy;
  logic [7:0] sfr_rdata;
  logic       ale_o;
  logic       pump_en_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  aux_ale_ctl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .sfr_we    (sfr_we),
    .sfr_re    (sfr_re),
    .xmem_busy (xmem_busy),
    .sfr_rdata (sfr_rdata),
    .ale_o     (ale_o),
    .pump_en_o (pump_en_o)
  );

  // {addr, wdata, we, re, expected rdata, expected pump}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h06, 1'b1},
    {8'h8E, 8'hFF, 1'b1, 1'b1, 8'h06, 1'b1},
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h07, 1'b1},
    {8'h8F, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
    {8'h8F, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1},
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h07, 1'b1},
    {8'h8E, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1},
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h07, 1'b1},
    {8'h8E, 8'hFC, 1'b1, 1'b0, 8'h00, 1'b1},
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h04, 1'b0},
    {8'h8E, 8'h02, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h06, 1'b1},
    {8'h8E, 8'h01, 1'b1, 1'b1, 8'h06, 1'b1},
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h05, 1'b0},
    {8'h0E, 8'h02, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h8E, 8'h00, 1'b0, 1'b1, 8'h05, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_now(input logic [7:0] d);
    sfr_addr = 8'h8E; sfr_wdata = d; sfr_we = 1'b1;
  endtask

  task automatic find_slot();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ale_o) break;
    end
    check("R6 slot found", {7'd0, ale_o}, 8'd1);
  endtask

  initial begin
    rst_n = 1'b0; sfr_addr = '0; sfr_wdata = '0; sfr_we = 0; sfr_re = 0; xmem_busy = 0;
    cyc(3);
    // R2: reset state
    sfr_addr = 8'h8E; sfr_re = 1'b1; #1;
    check("R2 reset rdata", sfr_rdata, 8'h06);
    check("R2 reset pump", {7'd0, pump_en_o}, 8'd1);
    check("R2 reset ale", {7'd0, ale_o}, 8'd0);
    sfr_re = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(1); check("R6 startup edge1", {7'd0, ale_o}, 8'd0);
    cyc(1); check("R6 startup edge2", {7'd0, ale_o}, 8'd0);
    cyc(1); check("R6 first pulse", {7'd0, ale_o}, 8'd1);
    for (int k = 1; k < 13; k++) begin
      cyc(1);
      check("R6 free run", {7'd0, ale_o}, (k % 6 == 0) ? 8'd1 : 8'd0);
    end

    // R1 R3 R4 R5: register vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {sfr_addr, sfr_wdata, sfr_we, sfr_re} = VEC[v][26:9];
      #1;
      check($sformatf("R1 R3 R4 vec%0d rdata", v), sfr_rdata, VEC[v][8:1]);
      check($sformatf("R5 vec%0d pump", v), {7'd0, pump_en_o}, {7'd0, VEC[v][0]});
    end
    @(negedge clk);
    wr_now(8'h06); sfr_re = 1'b0;
    @(negedge clk); sfr_we = 1'b0;

    // R7: gated mode, align to a slot (ph0)
    find_slot();
    wr_now(8'h07);
    cyc(1); sfr_we = 1'b0;              // ph1
    cyc(4);                              // ph5, busy low
    cyc(1); check("R7 gated no busy", {7'd0, ale_o}, 8'd0);   // ph0
    cyc(5); xmem_busy = 1'b1;            // ph5
    cyc(1); xmem_busy = 1'b0;
    check("R7 gated busy pulse", {7'd0, ale_o}, 8'd1);       // ph0
    cyc(1); check("R6 one clock wide", {7'd0, ale_o}, 8'd0); // ph1
    cyc(1); xmem_busy = 1'b1;            // ph2
    cyc(1); xmem_busy = 1'b0;            // ph3
    cyc(2);                              // ph5
    cyc(1); check("R7 mid-cycle busy ignored", {7'd0, ale_o}, 8'd0); // ph0

    // R8: mode writes in the boundary clock
    cyc(5); wr_now(8'h06);               // ph5, back to free
    cyc(1); sfr_we = 1'b0;
    check("R8 old gated slot", {7'd0, ale_o}, 8'd0);
    cyc(6); check("R8 new free slot", {7'd0, ale_o}, 8'd1);
    cyc(5); wr_now(8'h07);               // ph5, to gated
    cyc(1); sfr_we = 1'b0;
    check("R8 old free slot", {7'd0, ale_o}, 8'd1);
    cyc(1); check("R8 no long pulse", {7'd0, ale_o}, 8'd0);
    cyc(5); check("R8 new gated slot", {7'd0, ale_o}, 8'd0);

    // R2: asynchronous reset mid-run
    cyc(1); rst_n = 1'b0; sfr_addr = 8'h8E; sfr_re = 1'b1; #1;
    check("R2 mid-run reset rdata", sfr_rdata, 8'h06);
    check("R2 mid-run reset ale", {7'd0, ale_o}, 8'd0);
    cyc(2);
    check("R2 held reset ale", {7'd0, ale_o}, 8'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule